// File: doc/BRIEF.md
# Synchronous Frame Transmit Interrupt Latch

This block keeps the transmit-buffer-empty interrupt-pending flag for a byte-oriented synchronous frame transmitter. The host writes bytes into a one-byte transmit buffer. A small serializer moves each byte into a shift register at a byte-slot boundary and sends it least-significant bit first, one bit per clock. Once the last data byte has gone out with the end-of-message indication held, the serializer steps through two CRC byte slots and one closing-flag slot, then falls back to idle flags. The CRC slots carry a stub all-zero pattern.

Each move of a byte out of the buffer raises a buffer-empty event, and so does the entry into the first CRC slot. The events are counted in a two-entry counter, and the pending bit stays set while any event is outstanding. Each host clear command removes exactly one event. The data-empty event and the CRC-entry event at the end of a frame are therefore two separate interrupts. Clearing the first one late, after the second has already arrived, does not swallow the second. The interrupt request is the pending bit gated by an enable input.

Top module: `txe_irq_latch`

## Requirements
- R1: While rst_n is low, and after its release, buf_empty_o is 1, ip_o is 0, irq_o is 0 and phase_o is idle (code 0).
- R2: A host write (wr_buf_i high for one cycle) clears buf_empty_o from the next clock edge.
- R3: At a byte-slot boundary (every W clocks) with the buffer full, outside the CRC slots, the byte moves to the shift register. On that edge buf_empty_o rises, phase_o becomes data (code 1) and ip_o is set.
- R4: irq_o is high exactly when ip_o and irq_en_i are both high.
- R5: If the buffer is empty and eom_i is high when a data slot ends, phase_o goes to CRC1 (code 2) and one pending event is raised. W clocks later phase_o goes to CRC2 (code 3), W clocks after that to closing flag (code 4), and W clocks after that to idle (code 0).
- R6: Up to two events are held, and further events merge into the count. ip_o stays high while the count is non-zero. Each clr_tbe_i pulse removes one event, so a data-empty event and a CRC-entry event need two clears, even when the first clear comes after the CRC event.
- R7: A clr_tbe_i pulse with no event outstanding leaves ip_o at 0, and the count does not wrap.
- R8: Once CRC1 has been entered, dropping eom_i affects neither the CRC-entry event nor the rest of the CRC/flag sequence.
- R9: If eom_i is low when a data slot ends with the buffer empty, the serializer returns to idle (code 0) and raises no extra event.
- R10: txd_o sends a data byte least-significant bit first, with bit i in the i-th clock of its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_buf_i | input | 1 | Host write strobe for the transmit buffer |
| wr_data_i | input | W | Byte written to the buffer |
| eom_i | input | 1 | End-of-message latch level |
| clr_tbe_i | input | 1 | Host command that clears one buffer-empty interrupt |
| irq_en_i | input | 1 | Interrupt enable |
| buf_empty_o | output | 1 | Transmit buffer empty status |
| ip_o | output | 1 | Interrupt pending |
| irq_o | output | 1 | Interrupt request |
| phase_o | output | 3 | Frame phase: 0 idle, 1 data, 2 CRC1, 3 CRC2, 4 closing flag |
| txd_o | output | 1 | Serial data out |

## Verification
The frame-end interrupts are tried with three clear patterns. With no clear until both events are in, two clears are needed. With a clear between the data-empty event and CRC entry, one event remains. With an extra clear on an empty count, nothing underflows. Together these separate a true two-entry counter from a plain set/clear flag and from a wrapping counter. Frames ended with eom_i low, with eom_i dropped right after CRC entry, and with three unserviced data bytes show that the CRC event depends only on the condition at the data-slot end, and that the count saturates. A single-byte transfer checks slot timing and bit order on txd_o.

// File: rtl/txfr_pkg.sv
package txfr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DATA = 3'd1,
    PH_CRC1 = 3'd2,
    PH_CRC2 = 3'd3,
    PH_FLAG = 3'd4
  } txfr_phase_e;
endpackage

// File: rtl/txfr_serializer.sv
module txfr_serializer
  import txfr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] FLAG_PAT = W'('h7E)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         eom_i,
  output logic         buf_empty_o,
  output logic         empty_evt_o,
  output logic         crc_evt_o,
  output txfr_phase_e  phase_o,
  output logic         txd_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          full_q, full_d;
  logic [W-1:0]  buf_q, buf_d;
  logic [W-1:0]  sreg_q, sreg_d;
  logic [CW-1:0] bcnt_q, bcnt_d;
  txfr_phase_e   phase_q, phase_d;
  logic          slot_end, load, crc_go;

  assign slot_end = (bcnt_q == LAST);

  always_comb begin
    bcnt_d  = slot_end ? '0 : bcnt_q + CW'(1);
    sreg_d  = sreg_q >> 1;
    phase_d = phase_q;
    load    = 1'b0;
    crc_go  = 1'b0;
    if (slot_end) begin
      if (phase_q == PH_CRC1) begin
        phase_d = PH_CRC2;
        sreg_d  = '0;
      end else if (phase_q == PH_CRC2) begin
        phase_d = PH_FLAG;
        sreg_d  = FLAG_PAT;
      end else if (full_q) begin
        load    = 1'b1;
        phase_d = PH_DATA;
        sreg_d  = buf_q;
      end else if (phase_q == PH_DATA && eom_i) begin
        crc_go  = 1'b1;
        phase_d = PH_CRC1;
        sreg_d  = '0;
      end else begin
        phase_d = PH_IDLE;
        sreg_d  = FLAG_PAT;
      end
    end
  end

  always_comb begin
    full_d = full_q;
    buf_d  = buf_q;
    if (wr_i) begin
      full_d = 1'b1;
      buf_d  = data_i;
    end else if (load) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      buf_q   <= '0;
      sreg_q  <= FLAG_PAT;
      bcnt_q  <= '0;
      phase_q <= PH_IDLE;
    end else begin
      full_q  <= full_d;
      bcnt_q  <= bcnt_d;
      sreg_q  <= sreg_d;
      phase_q <= phase_d;
      if (wr_i) buf_q <= buf_d;
    end
  end

  assign buf_empty_o = ~full_q;
  assign empty_evt_o = load & ~wr_i;
  assign crc_evt_o   = crc_go;
  assign phase_o     = phase_q;
  assign txd_o       = sreg_q[0];
endmodule

// File: rtl/txfr_evt_counter.sv
module txfr_evt_counter #(
  parameter int MAX_EVT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic pend_o
);
  localparam int NW = $clog2(MAX_EVT + 1);
  localparam logic [NW-1:0] TOP = NW'(MAX_EVT);

  logic [NW-1:0] cnt_q, cnt_d;
  logic          dec, inc;

  always_comb begin
    dec   = clr_i && (cnt_q != '0);
    inc   = evt_i && ((cnt_q != TOP) || dec);
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + NW'(1);
    else if (dec && !inc) cnt_d = cnt_q - NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc != dec) cnt_q <= cnt_d;
  end

  assign pend_o = (cnt_q != '0);
endmodule

// File: rtl/txe_irq_latch.sv
module txe_irq_latch
  import txfr_pkg::*;
#(
  parameter int W       = 8,
  parameter int MAX_EVT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_buf_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         eom_i,
  input  logic         clr_tbe_i,
  input  logic         irq_en_i,
  output logic         buf_empty_o,
  output logic         ip_o,
  output logic         irq_o,
  output logic [2:0]   phase_o,
  output logic         txd_o
);
  logic        empty_evt, crc_evt, any_evt;
  txfr_phase_e phase;

  txfr_serializer #(.W(W)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (wr_buf_i),
    .data_i      (wr_data_i),
    .eom_i       (eom_i),
    .buf_empty_o (buf_empty_o),
    .empty_evt_o (empty_evt),
    .crc_evt_o   (crc_evt),
    .phase_o     (phase),
    .txd_o       (txd_o)
  );

  assign any_evt = empty_evt | crc_evt;

  txfr_evt_counter #(.MAX_EVT(MAX_EVT)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (any_evt),
    .clr_i  (clr_tbe_i),
    .pend_o (ip_o)
  );

  assign irq_o   = ip_o & irq_en_i;
  assign phase_o = phase;
endmodule

// File: rtl/txfr_chk.sv
module txfr_chk
  import txfr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_buf_i,
  input logic       clr_tbe_i,
  input logic       buf_empty_o,
  input logic       ip_o,
  input logic [2:0] phase_o,
  input logic       evt
);
  // R2
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_buf_i |=> !buf_empty_o);

  // R3
  load_raises_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty_o) |-> (phase_o == PH_DATA && ip_o));

  // R5
  crc_entry_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_CRC1 && $past(phase_o) == PH_DATA) |-> ip_o);

  // R5
  crc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_CRC1) |=> (phase_o == PH_CRC1 || phase_o == PH_CRC2));

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_o && !clr_tbe_i) |=> ip_o);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ip_o && clr_tbe_i && !evt) |=> !ip_o);
endmodule

bind txe_irq_latch txfr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_buf_i    (wr_buf_i),
  .clr_tbe_i   (clr_tbe_i),
  .buf_empty_o (buf_empty_o),
  .ip_o        (ip_o),
  .phase_o     (phase_o),
  .evt         (any_evt)
);

// File: tb/tb_txe_irq_latch.sv
`timescale 1ns/1ps
module tb_txe_irq_latch;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_buf_i, eom_i, clr_tbe_i, irq_en_i;
  logic [W-1:0] wr_data_i;
  logic         buf_empty_o, ip_o, irq_o, txd_o;
  logic [2:0]   phase_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  txe_irq_latch #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_buf_i(wr_buf_i), .wr_data_i(wr_data_i),
    .eom_i(eom_i), .clr_tbe_i(clr_tbe_i), .irq_en_i(irq_en_i),
    .buf_empty_o(buf_empty_o), .ip_o(ip_o), .irq_o(irq_o),
    .phase_o(phase_o), .txd_o(txd_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_byte(input logic [W-1:0] b);
    @(negedge clk);
    wr_buf_i  = 1'b1;
    wr_data_i = b;
    @(negedge clk);
    wr_buf_i  = 1'b0;
    chk("R2", "buf_empty after write", int'(buf_empty_o), 0);
  endtask

  task automatic clear_once();
    @(negedge clk);
    clr_tbe_i = 1'b1;
    @(negedge clk);
    clr_tbe_i = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 3 * W && !buf_empty_o; i++) @(negedge clk);
  endtask

  task automatic wait_phase(input logic [2:0] p);
    for (int i = 0; i < 6 * W && phase_o != p; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_buf_i = 1'b0; wr_data_i = '0; eom_i = 1'b0;
    clr_tbe_i = 1'b0; irq_en_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "buf_empty in reset", int'(buf_empty_o), 1);
    chk("R1", "ip in reset", int'(ip_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ip after reset", int'(ip_o), 0);
    chk("R1", "irq after reset", int'(irq_o), 0);
    chk("R1", "phase after reset", int'(phase_o), 0);
  endtask

  task automatic t_load_and_bits();
    logic [W-1:0] b = 8'hA5;
    write_byte(b);
    wait_empty();
    chk("R3", "buf_empty after load", int'(buf_empty_o), 1);
    chk("R3", "phase after load", int'(phase_o), 1);
    chk("R3", "ip after load", int'(ip_o), 1);
    chk("R10", "txd bit 0", int'(txd_o), int'(b[0]));
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      chk("R10", "txd bit", int'(txd_o), int'(b[i]));
    end
    irq_en_i = 1'b0;
    #1 chk("R4", "irq masked", int'(irq_o), 0);
    irq_en_i = 1'b1;
    #1 chk("R4", "irq enabled", int'(irq_o), 1);
    clear_once();
    chk("R6", "ip after single clear", int'(ip_o), 0);
    chk("R4", "irq after clear", int'(irq_o), 0);
    wait_phase(3'd0);
    chk("R9", "idle after unterminated data", int'(phase_o), 0);
    repeat (W) @(negedge clk);
    chk("R9", "no extra event", int'(ip_o), 0);
  endtask

  task automatic t_frame_late_clear();
    eom_i = 1'b1;
    write_byte(8'h3C);
    wait_empty();
    chk("R3", "ip on data empty", int'(ip_o), 1);
    wait_phase(3'd2);
    chk("R5", "phase CRC1", int'(phase_o), 2);
    chk("R5", "ip at CRC1", int'(ip_o), 1);
    repeat (W) @(negedge clk);
    chk("R5", "phase CRC2", int'(phase_o), 3);
    repeat (W) @(negedge clk);
    chk("R5", "phase flag", int'(phase_o), 4);
    repeat (W) @(negedge clk);
    chk("R5", "phase idle", int'(phase_o), 0);
    eom_i = 1'b0;
    clear_once();
    chk("R6", "ip after late first clear", int'(ip_o), 1);
    clear_once();
    chk("R6", "ip after second clear", int'(ip_o), 0);
    clear_once();
    chk("R7", "clear on empty count", int'(ip_o), 0);
  endtask

  task automatic t_frame_early_clear();
    eom_i = 1'b1;
    write_byte(8'h81);
    wait_empty();
    clear_once();
    chk("R6", "ip after early clear", int'(ip_o), 0);
    wait_phase(3'd2);
    eom_i = 1'b0;
    chk("R8", "ip at CRC1", int'(ip_o), 1);
    repeat (W) @(negedge clk);
    chk("R8", "CRC2 after eom drop", int'(phase_o), 3);
    chk("R8", "ip kept after eom drop", int'(ip_o), 1);
    clear_once();
    chk("R6", "ip after one clear", int'(ip_o), 0);
    wait_phase(3'd0);
  endtask

  task automatic t_underflow_then_event();
    clear_once();
    clear_once();
    chk("R7", "ip after idle clears", int'(ip_o), 0);
    write_byte(8'h11);
    wait_empty();
    chk("R7", "ip after event", int'(ip_o), 1);
    clear_once();
    chk("R7", "ip after clear, no wrap", int'(ip_o), 0);
    wait_phase(3'd0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 3; k++) begin
      write_byte(8'(k + 5));
      wait_empty();
    end
    wait_phase(3'd0);
    chk("R9", "no CRC without eom", int'(phase_o), 0);
    clear_once();
    chk("R6", "ip after first of two clears", int'(ip_o), 1);
    clear_once();
    chk("R6", "ip after saturated count drained", int'(ip_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_load_and_bits();
    t_frame_late_clear();
    t_frame_early_clear();
    t_underflow_then_event();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule